// File: doc/BRIEF.md
# LPC Memory Read Target

This block is the target side of a Low Pin Count bus for memory reads. It watches a 4-bit multiplexed address/data bus, with an active-low frame strobe, on every rising edge of the bus clock. The bus clock runs at the usual 33 MHz rate. When the host frames a memory read, the block collects the cycle-type nibble and then the 32-bit address, which arrives as eight nibbles with the most significant nibble first. At the end of the address it decides whether the cycle is its own.

A cycle is claimed only when it targets the top of the 4 GB space and the identity bits in the address match a 4-bit strap input. One address bit then steers the access either to a byte array or to register space. For a claimed cycle the block takes the bus after the turnaround, inserts two wait syncs, sends a ready sync and returns the byte as two nibbles. It then drives the bus high for one clock and releases it. Every claimed cycle lasts 19 clocks, counted from START. The byte comes from one of two read-data inputs, chosen by the select outputs. The full captured address is presented alongside.

Top module: `lpc_rd_target`

## Requirements
- R1: While rst_ni is low, and after it is released, lad_oe_o, arr_rd_o and reg_rd_o are all 0.
- R2: A cycle begins on a clock where lframe_ni is 0 and lad_i is 0000b. A frame clock with any other nibble starts nothing, and the block never drives the bus for it.
- R3: The nibble after START must read 010b on bits 3:2:1 (bits 3:2 = 01 for memory, bit 1 = 0 for read; bit 0 is ignored). Any other value, such as 0110b for a write, produces no response.
- R4: The eight address nibbles arrive most significant first. The block responds only when address bits 31:26 are all 1 and {a25,a24,a23,a21} equals strap_id_i[3:0]. Any other address leaves the bus undriven for the rest of the cycle.
- R5: For a claimed cycle, address bit 22 = 1 raises arr_rd_o and bit 22 = 0 raises reg_rd_o. The select is high from the first turnaround clock through the ready sync. Both selects are never high together, and acc_addr_o holds the full address, stable, while either select is high.
- R6: The block leaves the bus floating in the first turnaround clock after the address. In the second turnaround clock it drives 1111b.
- R7: Next the block drives 0101b for two clocks (wait), then 0000b for one clock (ready).
- R8: The byte is returned over the next two clocks, bits 3:0 first and then bits 7:4. It is taken from arr_rdata_i when arr_rd_o is high, and from reg_rdata_i otherwise.
- R9: After the data the block drives 1111b for one clock and then floats. The claimed cycle spans 19 clocks from START, and the block is ready for a new START on the next clock.
- R10: lframe_ni going low in any clock of a cycle aborts it: the bus is released on the next clock. If the nibble in that clock is 0000b, it begins a new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lframe_ni | input | 1 | Frame strobe from host, active low |
| lad_i | input | 4 | Multiplexed bus nibble as seen on the pins |
| lad_o | output | 4 | Nibble driven by the target |
| lad_oe_o | output | 1 | Output enable for lad_o |
| strap_id_i | input | 4 | Device identity matched against {a25,a24,a23,a21} |
| acc_addr_o | output | 32 | Captured cycle address |
| arr_rd_o | output | 1 | Claimed read targets the byte array |
| reg_rd_o | output | 1 | Claimed read targets register space |
| arr_rdata_i | input | 8 | Byte from the array for acc_addr_o |
| reg_rdata_i | input | 8 | Byte from register space for acc_addr_o |

## Verification
The bench sends addresses that miss the window by a single bit: bit 31, bit 26, a24 and a21. A decoder that checks too few bits would answer these and drive the bus. It also sends a write cycle-type and a START nibble other than 0000b, where a loose nibble compare would claim the cycle. Every slot of a claimed cycle is compared, so a swapped nibble order, a missing wait clock or a skipped final 1111b shows up as a mismatch in a named slot. Aborts are placed both in the address phase and in the data phase, and the strap is changed. A design that ignored the mid-cycle frame would keep driving the bus, and one that compared against a fixed identity would miss the re-strapped address.

// File: rtl/lpc_rd_pkg.sv
package lpc_rd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CTYP, ST_ADDR, ST_TAR0, ST_TAR1,
    ST_WSYNC, ST_RSYNC, ST_DATA, ST_TEND0, ST_TEND1
  } lpc_st_e;

  localparam logic [3:0] NIB_START = 4'h0;
  localparam logic [3:0] NIB_TAR   = 4'hF;
  localparam logic [3:0] NIB_WSYNC = 4'h5;
  localparam logic [3:0] NIB_RSYNC = 4'h0;
  localparam logic [2:0] CTYP_MRD  = 3'b010;

  localparam int WIN_LSB = 26;
  localparam int SEL_BIT = 22;

endpackage

// File: rtl/lpc_addr_shift.sv
module lpc_addr_shift #(
  parameter int NIB = 8,
  localparam int AW = 4 * NIB
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_en_i,
  input  logic [3:0]    nib_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] next_o
);

  logic [3:0] lane_q [NIB];

  for (genvar g = 0; g < NIB; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         lane_q[g] <= '0;
      else if (shift_en_i) lane_q[g] <= (g == 0) ? nib_i : lane_q[(g == 0) ? 0 : g-1];
    end
    assign addr_o[4*g +: 4] = lane_q[g];
    if (g == 0) begin : g_low
      assign next_o[3:0] = nib_i;
    end else begin : g_up
      assign next_o[4*g +: 4] = lane_q[g-1];
    end
  end

endmodule

// File: rtl/lpc_addr_decode.sv
module lpc_addr_decode
  import lpc_rd_pkg::*;
(
  input  logic [31:0] addr_i,
  input  logic [3:0]  strap_i,
  output logic        hit_o,
  output logic        arr_o
);

  logic       in_win;
  logic [3:0] id;

  assign in_win = &addr_i[31:WIN_LSB];
  assign id     = {addr_i[25:23], addr_i[21]};
  assign hit_o  = in_win && (id == strap_i);
  assign arr_o  = addr_i[SEL_BIT];

endmodule

// File: rtl/lpc_rd_fsm.sv
module lpc_rd_fsm
  import lpc_rd_pkg::*;
#(
  parameter int ADDR_NIB = 8,
  parameter int WSYNC_N  = 2,
  localparam int CW      = $clog2(ADDR_NIB),
  localparam logic [CW-1:0] ADDR_LAST  = CW'(ADDR_NIB - 1),
  localparam logic [CW-1:0] WSYNC_LAST = CW'(WSYNC_N - 1),
  localparam logic [CW-1:0] DATA_LAST  = CW'(1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lframe_ni,
  input  logic [3:0] lad_i,
  input  logic       hit_i,
  input  logic       arr_i,
  input  logic [7:0] rdata_i,
  output logic       shift_en_o,
  output logic [3:0] lad_o,
  output logic       lad_oe_o,
  output logic       arr_rd_o,
  output logic       reg_rd_o
);

  lpc_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          arr_q;
  logic [7:0]    byte_q;
  logic          in_acc;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!lframe_ni) begin
      st_d  = (lad_i == NIB_START) ? ST_CTYP : ST_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE:  st_d = ST_IDLE;
        ST_CTYP: begin
          st_d  = (lad_i[3:1] == CTYP_MRD) ? ST_ADDR : ST_IDLE;
          cnt_d = '0;
        end
        ST_ADDR: begin
          if (cnt_q == ADDR_LAST) begin
            st_d  = hit_i ? ST_TAR0 : ST_IDLE;
            cnt_d = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_TAR0:  st_d = ST_TAR1;
        ST_TAR1: begin
          st_d  = ST_WSYNC;
          cnt_d = '0;
        end
        ST_WSYNC: begin
          if (cnt_q == WSYNC_LAST) st_d = ST_RSYNC;
          else                     cnt_d = cnt_q + 1'b1;
        end
        ST_RSYNC: begin
          st_d  = ST_DATA;
          cnt_d = '0;
        end
        ST_DATA: begin
          if (cnt_q == DATA_LAST) st_d = ST_TEND0;
          else                    cnt_d = cnt_q + 1'b1;
        end
        ST_TEND0: st_d = ST_TEND1;
        ST_TEND1: st_d = ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // space select latched with the last address nibble
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arr_q <= 1'b0;
    else if (st_q == ST_ADDR && cnt_q == ADDR_LAST && lframe_ni) arr_q <= arr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                byte_q <= '0;
    else if (st_q == ST_RSYNC)  byte_q <= rdata_i;
    else if (st_q == ST_DATA)   byte_q <= {4'h0, byte_q[7:4]};
  end

  assign shift_en_o = (st_q == ST_ADDR) && lframe_ni;
  assign in_acc     = (st_q == ST_TAR0) || (st_q == ST_TAR1) ||
                      (st_q == ST_WSYNC) || (st_q == ST_RSYNC);
  assign arr_rd_o   = in_acc && arr_q;
  assign reg_rd_o   = in_acc && !arr_q;

  always_comb begin
    lad_oe_o = 1'b1;
    unique case (st_q)
      ST_TAR1, ST_TEND0: lad_o = NIB_TAR;
      ST_WSYNC:          lad_o = NIB_WSYNC;
      ST_RSYNC:          lad_o = NIB_RSYNC;
      ST_DATA:           lad_o = byte_q[3:0];
      default: begin
        lad_o    = 4'h0;
        lad_oe_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/lpc_rd_target.sv
module lpc_rd_target #(
  parameter int ADDR_NIB = 8,
  parameter int WSYNC_N  = 2,
  localparam int AW      = 4 * ADDR_NIB
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lframe_ni,
  input  logic [3:0]    lad_i,
  output logic [3:0]    lad_o,
  output logic          lad_oe_o,
  input  logic [3:0]    strap_id_i,
  output logic [AW-1:0] acc_addr_o,
  output logic          arr_rd_o,
  output logic          reg_rd_o,
  input  logic [7:0]    arr_rdata_i,
  input  logic [7:0]    reg_rdata_i
);

  logic          shift_en;
  logic [AW-1:0] addr_next;
  logic          hit, arr_sel;
  logic [7:0]    rdata;

  lpc_addr_shift #(.NIB(ADDR_NIB)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_en),
    .nib_i      (lad_i),
    .addr_o     (acc_addr_o),
    .next_o     (addr_next)
  );

  lpc_addr_decode u_dec (
    .addr_i  (addr_next[31:0]),
    .strap_i (strap_id_i),
    .hit_o   (hit),
    .arr_o   (arr_sel)
  );

  assign rdata = arr_rd_o ? arr_rdata_i : reg_rdata_i;

  lpc_rd_fsm #(.ADDR_NIB(ADDR_NIB), .WSYNC_N(WSYNC_N)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lframe_ni  (lframe_ni),
    .lad_i      (lad_i),
    .hit_i      (hit),
    .arr_i      (arr_sel),
    .rdata_i    (rdata),
    .shift_en_o (shift_en),
    .lad_o      (lad_o),
    .lad_oe_o   (lad_oe_o),
    .arr_rd_o   (arr_rd_o),
    .reg_rd_o   (reg_rd_o)
  );

endmodule

// File: rtl/lpc_rd_target_chk.sv
module lpc_rd_target_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          lframe_ni,
  input logic [3:0]    lad_i,
  input logic [3:0]    lad_o,
  input logic          lad_oe_o,
  input logic [AW-1:0] acc_addr_o,
  input logic          arr_rd_o,
  input logic          reg_rd_o
);

  assert_sel_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(arr_rd_o && reg_rd_o));

  assert_addr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((arr_rd_o || reg_rd_o) && $past(arr_rd_o || reg_rd_o)) |-> $stable(acc_addr_o));

  assert_take_bus_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lad_oe_o) |-> (lad_o == 4'hF && $past(arr_rd_o || reg_rd_o)));

  assert_wsync_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lad_oe_o && lad_o == 4'h5 && $past(lad_oe_o && lad_o == 4'hF) && lframe_ni)
      |=> (lad_oe_o && lad_o == 4'h5));

  assert_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(lad_oe_o) && $past(lframe_ni)) |-> ($past(lad_o) == 4'hF));

  assert_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lframe_ni && lad_i != 4'h0) |=> !lad_oe_o);

endmodule

bind lpc_rd_target lpc_rd_target_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_lpc_rd_target.sv
`timescale 1ns/1ps
module tb_lpc_rd_target;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lframe_ni = 1'b1;
  logic [3:0]  lad_i = 4'hF;
  logic [3:0]  lad_o;
  logic        lad_oe_o;
  logic [3:0]  strap = 4'hA;
  logic [31:0] acc_addr;
  logic        arr_rd, reg_rd;
  logic [7:0]  arr_rdata, reg_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // bench memory model
  assign arr_rdata = acc_addr[7:0] ^ 8'h3C;
  assign reg_rdata = ~acc_addr[7:0];

  lpc_rd_target dut (
    .clk_i(clk), .rst_ni(rst_ni), .lframe_ni(lframe_ni), .lad_i(lad_i),
    .lad_o(lad_o), .lad_oe_o(lad_oe_o), .strap_id_i(strap),
    .acc_addr_o(acc_addr), .arr_rd_o(arr_rd), .reg_rd_o(reg_rd),
    .arr_rdata_i(arr_rdata), .reg_rdata_i(reg_rdata)
  );

  // {addr, cyctype nibble, expect claim}; strap 4'hA
  localparam int NV = 9;
  localparam logic [36:0] VEC [NV] = '{
    {32'hFEC12345, 4'h4, 1'b1},
    {32'hFE8ABC5A, 4'h4, 1'b1},
    {32'hFEC000F0, 4'h5, 1'b1},
    {32'hFE8000FF, 4'h4, 1'b1},
    {32'hFEC12345, 4'h6, 1'b0},
    {32'h7EC12345, 4'h4, 1'b0},
    {32'hFFC12345, 4'h4, 1'b0},
    {32'hFEE12345, 4'h4, 1'b0},
    {32'hFBC12345, 4'h4, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic drive(input logic lfn, input logic [3:0] nib);
    lframe_ni = lfn;
    lad_i = nib;
    @(posedge clk);
    @(negedge clk);
  endtask

  // one read cycle of up to nslot clocks; observe after each edge
  task automatic run_read(input logic [3:0] st_nib, input logic [31:0] a,
                          input logic [3:0] cyc, input logic exp_hit,
                          input int nslot, input string tag);
    logic [7:0] eb;
    eb = a[22] ? (a[7:0] ^ 8'h3C) : ~a[7:0];
    for (int i = 0; i < nslot; i++) begin
      logic [4:0] exp_v;
      string req;
      if (i == 0)      drive(1'b0, st_nib);
      else if (i == 1) drive(1'b1, cyc);
      else if (i < 10) drive(1'b1, a[31-4*(i-2) -: 4]);
      else             drive(1'b1, 4'hF);
      exp_v = 5'h00;
      req = tag;
      if (exp_hit) begin
        case (i)
          10:      begin exp_v = 5'h1F; req = "R6"; end
          11, 12:  begin exp_v = 5'h15; req = "R7"; end
          13:      begin exp_v = 5'h10; req = "R7"; end
          14:      begin exp_v = {1'b1, eb[3:0]}; req = "R8"; end
          15:      begin exp_v = {1'b1, eb[7:4]}; req = "R8"; end
          16:      begin exp_v = 5'h1F; req = "R9"; end
          17, 18:  begin exp_v = 5'h00; req = "R9"; end
          9:       begin exp_v = 5'h00; req = "R6"; end
          default: exp_v = 5'h00;
        endcase
      end
      chk(req, {lad_oe_o, (lad_oe_o ? lad_o : 4'h0)}, {27'd0, exp_v});
      if (exp_hit && i == 11) begin
        chk("R5 sel", {arr_rd, reg_rd}, {30'd0, a[22], !a[22]});
        chk("R5 addr", acc_addr, a);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 in reset", {lad_oe_o, arr_rd, reg_rd}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 after reset", {lad_oe_o, arr_rd, reg_rd}, 0);

    for (int v = 0; v < NV; v++) begin
      run_read(4'h0, VEC[v][36:5], VEC[v][4:1], VEC[v][0], 19,
               (VEC[v][4:1] == 4'h6) ? "R3" : "R4");
    end

    // bad START nibble: no claim
    run_read(4'h2, 32'hFEC12345, 4'h4, 1'b0, 19, "R2");
    // back-to-back claimed reads after a refused one
    run_read(4'h0, 32'hFEC00010, 4'h4, 1'b1, 19, "R9");

    // abort mid-address, restart in the same frame clock
    drive(1'b0, 4'h0);
    drive(1'b1, 4'h4);
    drive(1'b1, 4'hF);
    drive(1'b1, 4'hE);
    run_read(4'h0, 32'hFE800033, 4'h4, 1'b1, 19, "R10");

    // abort in the data phase with a non-start nibble
    run_read(4'h0, 32'hFEC00077, 4'h4, 1'b1, 15, "R10");
    drive(1'b0, 4'h3);
    chk("R10 abort release", {lad_oe_o, arr_rd, reg_rd}, 0);
    drive(1'b1, 4'hF);
    chk("R10 stays idle", {31'd0, lad_oe_o}, 0);
    run_read(4'h0, 32'hFEC000A5, 4'h4, 1'b1, 19, "R10");

    // identity follows the strap
    strap = 4'h5;
    run_read(4'h0, 32'hFD6000C3, 4'h4, 1'b1, 19, "R4");
    run_read(4'h0, 32'hFEC12345, 4'h4, 1'b0, 19, "R4");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule